// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects interrupt requests from a set of device lines and reports them to a processor over one interrupt output. A rising edge on any request line is captured in a pending register, so a request that lasts a single cycle is not lost. Among the pending lines that are not masked, the lowest-numbered line wins. When the global enable is on and no interrupt is in service, the controller raises its interrupt output and drives the winning line's index on a vector output.

The processor takes the interrupt by pulsing an acknowledge input. This clears the chosen line's pending bit and moves the controller into service. While in service no further interrupt is raised, whatever arrives. An end-of-service pulse releases the controller so the next pending request can be signalled. A small write port sets the global enable and a per-line mask.

The controller is a three-state machine. IDLE goes to SIGNAL on the transition *raise*, taken when enabled and an eligible request exists. SIGNAL goes to SERVICE on the transition *take*, taken when acknowledge is high. SERVICE goes back to IDLE on the transition *release*, taken when end-of-service is high. In every other case the state holds.

Top module: `prio_vec_intc`

## Requirements
- R1: No interrupt is raised while the global enable is 0. The enable is bit 0 written at config address 0 and is 0 after reset. A request that became pending while disabled is signalled once the enable is set.
- R2: When several eligible lines are pending, the lowest-numbered one is chosen. Line 0 has the highest priority.
- R3: Mask bit i is written at config address 1. When it is 1, line i is excluded from selection. Mask bits are 0 after reset. A masked request stays pending and is signalled after the line is unmasked.
- R4: Pending bits are set on a rising edge of the request line, so a one-cycle pulse is captured. A line held high after its request has been taken does not raise another interrupt.
- R5: A rising edge sampled at clock edge k makes `cpu_irq` high after edge k+1, with `vec_out` equal to the chosen line index. While idle, `cpu_irq` is 0 and `vec_out` is 0.
- R6: Once raised, `cpu_irq` stays high and `vec_out` stays unchanged until acknowledge. This holds even if a higher-priority request arrives in the meantime.
- R7: When acknowledge is sampled high while the interrupt is raised, `cpu_irq` drops after that edge and the chosen line's pending bit is cleared. `vec_out` stays unchanged during service.
- R8: While an interrupt is in service, `cpu_irq` stays 0 for any request activity.
- R9: When end-of-service is sampled high in service, the controller returns to idle after that edge. A remaining eligible request raises `cpu_irq` after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_lines | input | NUM_LINES | Device request lines, rising edge captured |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 1 | 0: global enable (bit 0), 1: line mask |
| cfg_wdata | input | NUM_LINES | Config write data |
| cpu_ack | input | 1 | Acknowledge pulse from processor |
| cpu_eos | input | 1 | End-of-service pulse from processor |
| cpu_irq | output | 1 | Interrupt request to processor |
| vec_out | output | VEC_W | Index of the chosen line |

## Verification
A request pulse sampled at one edge shows up on `cpu_irq` and `vec_out` after the second edge. This is because the pending register and the state register each add one stage. An acknowledge or end-of-service takes effect after the single edge that samples it. A following request is signalled one edge later than that. The bench drives inputs on the falling edge and samples outputs on the falling edge that follows the edge on which each result is due. It counts those edges explicitly, so a design that is early or late by one cycle is caught.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SIGNAL  = 2'd1,
        ST_SERVICE = 2'd2
    } pvic_state_e;
endpackage

// File: rtl/pvic_pending.sv
module pvic_pending #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] pend_o
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] rise;

    assign rise = req_i & ~prev_q;

    // a new edge on a line wins over a clear of the same line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= req_i;
            pend_q <= (pend_q & ~clr_i) | rise;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/pvic_resolver.sv
module pvic_resolver #(
    parameter int NUM_LINES = 8,
    localparam int VEC_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] elig_i,
    output logic                 any_o,
    output logic [VEC_W-1:0]     idx_o
);
    logic [NUM_LINES:0]   lower_any;
    logic [NUM_LINES-1:0] grant;

    assign lower_any[0] = 1'b0;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chain
        assign grant[g]       = elig_i[g] & ~lower_any[g];
        assign lower_any[g+1] = lower_any[g] | elig_i[g];
    end

    assign any_o = lower_any[NUM_LINES];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (grant[i]) idx_o = idx_o | VEC_W'(i);
        end
    end
endmodule

// File: rtl/pvic_ctrl.sv
module pvic_ctrl
    import pvic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int VEC_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glob_en_i,
    input  logic                 any_i,
    input  logic [VEC_W-1:0]     idx_i,
    input  logic                 ack_i,
    input  logic                 eos_i,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     vec_o,
    output logic                 in_service_o,
    output logic [NUM_LINES-1:0] clr_o
);
    pvic_state_e state_q, state_d;
    logic [VEC_W-1:0] hold_q;
    logic             do_raise;

    assign do_raise = (state_q == ST_IDLE) && glob_en_i && any_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (glob_en_i && any_i) state_d = ST_SIGNAL;   // raise
            ST_SIGNAL:  if (ack_i)              state_d = ST_SERVICE;  // take
            ST_SERVICE: if (eos_i)              state_d = ST_IDLE;     // release
            default:                            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (do_raise) hold_q <= idx_i;
        end
    end

    always_comb begin
        irq_o        = 1'b0;
        vec_o        = '0;
        in_service_o = 1'b0;
        clr_o        = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SIGNAL: begin
                irq_o = 1'b1;
                vec_o = hold_q;
                if (ack_i) clr_o = NUM_LINES'(1) << hold_q;
            end
            ST_SERVICE: begin
                vec_o        = hold_q;
                in_service_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
    parameter int NUM_LINES = 8,
    localparam int VEC_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_lines,
    input  logic                 cfg_wr,
    input  logic                 cfg_addr,
    input  logic [NUM_LINES-1:0] cfg_wdata,
    input  logic                 cpu_ack,
    input  logic                 cpu_eos,
    output logic                 cpu_irq,
    output logic [VEC_W-1:0]     vec_out
);
    logic                 glob_en;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] clr;
    logic                 any_elig;
    logic [VEC_W-1:0]     win_idx;
    logic                 in_service;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            mask_q  <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr) mask_q  <= cfg_wdata;
            else          glob_en <= cfg_wdata[0];
        end
    end

    pvic_pending #(.NUM_LINES(NUM_LINES)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_lines),
        .clr_i  (clr),
        .pend_o (pend)
    );

    pvic_resolver #(.NUM_LINES(NUM_LINES)) u_resolver (
        .elig_i (pend & ~mask_q),
        .any_o  (any_elig),
        .idx_o  (win_idx)
    );

    pvic_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .glob_en_i    (glob_en),
        .any_i        (any_elig),
        .idx_i        (win_idx),
        .ack_i        (cpu_ack),
        .eos_i        (cpu_eos),
        .irq_o        (cpu_irq),
        .vec_o        (vec_out),
        .in_service_o (in_service),
        .clr_o        (clr)
    );
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
    parameter int VEC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_irq,
    input logic [VEC_W-1:0] vec_out,
    input logic             cpu_ack,
    input logic             cpu_eos,
    input logic             glob_en,
    input logic             in_service
);
    a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(glob_en));

    a_r8_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !cpu_irq);

    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_irq) && !$past(cpu_ack)) |-> (cpu_irq && $stable(vec_out)));

    a_r7_take_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_irq) && $past(cpu_ack)) |-> (in_service && !cpu_irq && $stable(vec_out)));

    a_r9_release_leaves_service: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && cpu_eos) |=> !in_service);

    a_r5_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq && !in_service) |-> (vec_out == '0));
endmodule

bind prio_vec_intc pvic_checker #(.VEC_W(VEC_W)) u_pvic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_irq    (cpu_irq),
    .vec_out    (vec_out),
    .cpu_ack    (cpu_ack),
    .cpu_eos    (cpu_eos),
    .glob_en    (glob_en),
    .in_service (in_service)
);

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
    localparam int N  = 8;
    localparam int VW = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_lines = '0;
    logic         cfg_wr = 1'b0;
    logic         cfg_addr = 1'b0;
    logic [N-1:0] cfg_wdata = '0;
    logic         cpu_ack = 1'b0;
    logic         cpu_eos = 1'b0;
    logic         cpu_irq;
    logic [VW-1:0] vec_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prio_vec_intc #(.NUM_LINES(N)) i_prio_vec_intc (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cpu_ack(cpu_ack), .cpu_eos(cpu_eos),
        .cpu_irq(cpu_irq), .vec_out(vec_out)
    );

    // row: {mask, pulse lines, expected vector, expected irq}
    localparam logic [19:0] TBL [0:7] = '{
        {8'h00, 8'h01, 3'd0, 1'b1},
        {8'h00, 8'h80, 3'd7, 1'b1},
        {8'h00, 8'hA4, 3'd2, 1'b1},
        {8'h04, 8'hA4, 3'd5, 1'b1},
        {8'hFF, 8'h3C, 3'd0, 1'b0},
        {8'h00, 8'h00, 3'd0, 1'b0},
        {8'h0F, 8'h18, 3'd4, 1'b1},
        {8'h00, 8'h60, 3'd5, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_lines = '0; cfg_wr = 1'b0; cpu_ack = 1'b0; cpu_eos = 1'b0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic cfg_write(input logic a, input logic [N-1:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    // pulse for one cycle, then one more edge: result due now
    task automatic pulse(input logic [N-1:0] l);
        req_lines = l;
        step();
        req_lines = '0;
        step();
    endtask

    task automatic ack();
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
    endtask

    task automatic eos();
        cpu_eos = 1'b1;
        step();
        cpu_eos = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R5 reset state
        check("R5 reset irq", int'(cpu_irq), 0);
        check("R5 reset vec", int'(vec_out), 0);

        // table walk: R2 priority, R3 masking, R4 pulse capture, R5 vector, R7 take
        for (int k = 0; k < 8; k++) begin
            do_reset();
            cfg_write(1'b0, 8'h01);
            cfg_write(1'b1, TBL[k][19:12]);
            pulse(TBL[k][11:4]);
            check($sformatf("R2 R3 R4 row%0d irq", k), int'(cpu_irq), int'(TBL[k][0]));
            check($sformatf("R2 R3 R5 row%0d vec", k), int'(vec_out), int'(TBL[k][3:1]));
            if (TBL[k][0]) begin
                ack();
                check($sformatf("R7 row%0d irq drop", k), int'(cpu_irq), 0);
                check($sformatf("R7 row%0d vec held", k), int'(vec_out), int'(TBL[k][3:1]));
                eos();
            end
        end

        // R1: disabled blocks, enabling releases the pending line
        do_reset();
        pulse(8'h08);
        step();
        check("R1 disabled irq", int'(cpu_irq), 0);
        cfg_write(1'b0, 8'h01);
        check("R1 enable not yet", int'(cpu_irq), 0);
        step();
        check("R1 enabled irq", int'(cpu_irq), 1);
        check("R1 enabled vec", int'(vec_out), 3);

        // R6: higher-priority arrival does not change the raised vector
        do_reset();
        cfg_write(1'b0, 8'h01);
        pulse(8'h10);
        pulse(8'h01);
        step();
        check("R6 irq held", int'(cpu_irq), 1);
        check("R6 vec held", int'(vec_out), 4);
        ack();
        // R9: release, then line 0 raised one edge later
        eos();
        check("R9 idle after release", int'(cpu_irq), 0);
        step();
        check("R9 next irq", int'(cpu_irq), 1);
        check("R9 next vec", int'(vec_out), 0);
        ack();
        eos();
        step();
        // R7: line 4 was cleared on take, nothing left
        check("R7 cleared pending", int'(cpu_irq), 0);

        // R8: in service, requests do not raise
        do_reset();
        cfg_write(1'b0, 8'h01);
        pulse(8'h20);
        ack();
        pulse(8'h02);
        step();
        step();
        check("R8 quiet in service", int'(cpu_irq), 0);
        eos();
        step();
        check("R8 after release irq", int'(cpu_irq), 1);
        check("R8 after release vec", int'(vec_out), 1);

        // R4: held level does not retrigger
        do_reset();
        cfg_write(1'b0, 8'h01);
        req_lines = 8'h04;
        step();
        step();
        check("R4 level raise", int'(cpu_irq), 1);
        ack();
        eos();
        step();
        step();
        check("R4 level no retrigger", int'(cpu_irq), 0);
        req_lines = '0;

        // R3: masked stays pending, signalled after unmask
        do_reset();
        cfg_write(1'b0, 8'h01);
        cfg_write(1'b1, 8'h40);
        pulse(8'h40);
        step();
        check("R3 masked quiet", int'(cpu_irq), 0);
        cfg_write(1'b1, 8'h00);
        step();
        check("R3 unmask irq", int'(cpu_irq), 1);
        check("R3 unmask vec", int'(vec_out), 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule